// File: doc/BRIEF.md
# Display Bridge I2C Control Target

This block is the control-port target of a digital video transmitter bridge. A host reaches it as an I2C target at a fixed 7-bit address. The SCL and SDA lines are sampled through a synchroniser on the system clock. The block decodes the address, receives and sends bytes, and pulls SDA low for acknowledge bits and for zero data bits. It never drives SDA high. The first byte of every write transfer selects a register through an internal 8-bit pointer. Each later data byte, read or written, moves that pointer up by one.

The register set is small. A fixed identification value lets the host see that the device is present. An interrupt status register always reports an attached sink with nothing pending. A control byte carries a bus request/grant handshake. When the host writes request and grant together, the bridge enters display-data-channel pass-through mode and reports this on `ddc_mode_o`. Writing the control byte with the request bit clear leaves that mode.

A host normally writes the pointer and then issues a repeated start with the read direction. Because the pointer is kept across the repeated start, the read returns the selected register. The host can also run a plain read transfer, which continues from wherever the pointer last stood. During a read, the host acknowledges a byte to ask for the next one, or refuses it to end the transfer.

Top module: `bridge_i2c_ctl`

## Requirements
- R1: The block acknowledges (drives SDA low in the ninth clock) only an address byte whose upper seven bits equal `DEV_ADDR`. For any other address it leaves SDA released for the rest of the transfer.
- R2: In a write transfer, the first data byte after a start or repeated start is loaded into the register pointer. It does not change any register.
- R3: The pointer advances by one, wrapping from 0xFF to 0x00, after every data byte written (except the pointer byte) and after every byte sent to the host. This holds for unimplemented addresses too.
- R4: Reading address 0x1B returns the identification value `CHIP_ID` (0xB0 by default).
- R5: Reading address 0x3D returns 0x04 (sink attached, no interrupt pending).
- R6: Writing address 0x1A with bit 2 set sets the request flag. If bit 1 is also set in that byte, the block enters pass-through mode and `ddc_mode_o` goes high. `ddc_mode_o` is never high while the request flag is clear.
- R7: Writing address 0x1A with bit 2 clear clears both the request flag and pass-through mode.
- R8: Reading address 0x1A returns 0x06 while the request flag is set, and 0x00 otherwise.
- R9: Reading any address other than 0x1A, 0x1B and 0x3D returns 0x00. Writes to addresses other than 0x1A are acknowledged and change neither the request flag nor pass-through mode.
- R10: After reset the pointer is 0x00, the request flag and pass-through mode are clear, and SDA is released.
- R11: Every written byte is acknowledged. During a read, an acknowledge from the host makes the block send the next byte. A refusal (SDA high in the ninth clock) makes it release SDA until the next start condition.
- R12: A repeated start with the read direction keeps the pointer, so the read returns the register the preceding write selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain drive) |
| ddc_mode_o | output | 1 | High while pass-through mode is active |

## Verification
The bench builds the block with a non-default device address of 0x3B, so an address match cannot pass by luck at the default value. It also uses three synchroniser stages instead of two, which lengthens the delay between an SCL edge and the block's SDA response and tests the margin inside a bus half-period. With that address, the stray address 0x22 shows that a non-matching transfer is never acknowledged. Starting the pointer at 0xFF brings the wrap to 0x00 within reach in a single transfer.

// File: rtl/bridge_i2c_pkg.sv
package bridge_i2c_pkg;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ADDR_ACK,
    LK_WR,
    LK_WR_ACK,
    LK_RD,
    LK_RD_ACK
  } link_state_t;

  localparam int          BYTE_W      = 8;
  localparam logic [7:0]  REG_CTRL    = 8'h1A;
  localparam logic [7:0]  REG_ID      = 8'h1B;
  localparam logic [7:0]  REG_IRQ     = 8'h3D;
  localparam int          CTRL_REQ    = 2;
  localparam int          CTRL_GNT    = 1;
  localparam logic [7:0]  IRQ_PLUGGED = 8'h04;
  localparam logic [7:0]  CTRL_ECHO   = 8'h06;

endpackage

// File: rtl/bridge_i2c_sync.sv
module bridge_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/bridge_i2c_link.sv
module bridge_i2c_link
  import bridge_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  output logic        sda_oe,
  output logic        wr_valid,
  output logic        wr_first,
  output logic [7:0]  wr_data,
  output logic        rd_take,
  input  logic [7:0]  rd_data
);
  link_state_t state;
  logic [3:0]  cnt;
  logic [7:0]  shreg;
  logic [7:0]  tx;
  logic        rw;
  logic        first;
  logic        got_ack;

  assign wr_valid = scl_fall && (state == LK_WR) && (cnt == 4'd8);
  assign wr_first = first;
  assign wr_data  = shreg;
  assign rd_take  = scl_fall && (((state == LK_ADDR_ACK) && rw) ||
                                 ((state == LK_RD_ACK) && got_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= LK_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      first   <= 1'b0;
      got_ack <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state  <= LK_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= LK_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        LK_IDLE: sda_oe <= 1'b0;
        LK_ADDR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (shreg[7:1] == DEV_ADDR) begin
              state  <= LK_ADDR_ACK;
              rw     <= shreg[0];
              sda_oe <= 1'b1;
            end else begin
              state <= LK_IDLE;
            end
          end
        end
        LK_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state  <= LK_RD;
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state  <= LK_WR;
              first  <= 1'b1;
              sda_oe <= 1'b0;
            end
          end
        end
        LK_WR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            state  <= LK_WR_ACK;
            first  <= 1'b0;
            cnt    <= '0;
            sda_oe <= 1'b1;
          end
        end
        LK_WR_ACK: begin
          if (scl_fall) begin
            state  <= LK_WR;
            sda_oe <= 1'b0;
          end
        end
        LK_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              state  <= LK_RD_ACK;
              cnt    <= '0;
              sda_oe <= 1'b0;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        LK_RD_ACK: begin
          if (scl_rise) begin
            got_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (got_ack) begin
              state  <= LK_RD;
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              state <= LK_IDLE;
            end
          end
        end
        default: state <= LK_IDLE;
      endcase
    end
  end

  // R1: the line is only pulled in acknowledge slots or while sending data
  p_drive_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == LK_ADDR_ACK || state == LK_WR_ACK || state == LK_RD));

  // R11: once the link is idle (refusal, foreign address) SDA stays released
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_IDLE) |-> !sda_oe);

  // R3: a byte never spans more than eight bits
  p_bit_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);

endmodule

// File: rtl/bridge_i2c_regs.sv
module bridge_i2c_regs
  import bridge_i2c_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hB0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_first,
  input  logic [7:0] wr_data,
  input  logic       rd_take,
  output logic [7:0] rd_data,
  output logic       ddc_mode
);
  logic [7:0] ptr;
  logic       req;
  logic       ddc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      req <= 1'b0;
      ddc <= 1'b0;
    end else if (wr_valid && wr_first) begin
      ptr <= wr_data;
    end else if (wr_valid) begin
      ptr <= ptr + 8'd1;
      if (ptr == REG_CTRL) begin
        if (wr_data[CTRL_REQ]) begin
          req <= 1'b1;
          if (wr_data[CTRL_GNT]) ddc <= 1'b1;
        end else begin
          req <= 1'b0;
          ddc <= 1'b0;
        end
      end
    end else if (rd_take) begin
      ptr <= ptr + 8'd1;
    end
  end

  always_comb begin
    unique case (ptr)
      REG_CTRL: rd_data = req ? CTRL_ECHO : 8'h00;
      REG_ID:   rd_data = CHIP_ID;
      REG_IRQ:  rd_data = IRQ_PLUGGED;
      default:  rd_data = 8'h00;
    endcase
  end

  assign ddc_mode = ddc;

  // R2: the pointer byte lands in the pointer
  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_first) |=> (ptr == $past(wr_data)));

  // R3: every data byte moves the pointer by one
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_valid && !wr_first) || rd_take) |=> (ptr == $past(ptr) + 8'd1));

  // R6: pass-through mode needs the request flag
  p_mode_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ddc |-> req);

  // R7: control write without request leaves pass-through mode
  p_ctrl_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_first && ptr == REG_CTRL && !wr_data[CTRL_REQ]) |=> (!ddc && !req));

  // R9: writes elsewhere keep the mode state
  p_other_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_first && ptr != REG_CTRL) |=> ($stable(ddc) && $stable(req)));

endmodule

// File: rtl/bridge_i2c_ctl.sv
module bridge_i2c_ctl #(
  parameter logic [6:0] DEV_ADDR    = 7'h39,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CHIP_ID     = 8'hB0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic ddc_mode_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_valid, wr_first, rd_take;
  logic [7:0] wr_data, rd_data;

  bridge_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  bridge_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .wr_valid  (wr_valid),
    .wr_first  (wr_first),
    .wr_data   (wr_data),
    .rd_take   (rd_take),
    .rd_data   (rd_data)
  );

  bridge_i2c_regs #(.CHIP_ID(CHIP_ID)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_first (wr_first),
    .wr_data  (wr_data),
    .rd_take  (rd_take),
    .rd_data  (rd_data),
    .ddc_mode (ddc_mode_o)
  );

  // R10: right after reset the line is released and the mode is off
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sda_oe_o && !ddc_mode_o));

endmodule

// File: tb/bridge_i2c_ctl_bench.sv
`timescale 1ns/1ps
module bridge_i2c_ctl_bench;
  localparam logic [6:0] ADDR = 7'h3B;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, ddc_mode;
  logic sda_bus;

  always #4 clk = ~clk;
  assign sda_bus = !(m_low || sda_oe);

  bridge_i2c_ctl #(.DEV_ADDR(ADDR), .SYNC_STAGES(3), .CHIP_ID(8'hB0)) u_bridge_i2c_ctl (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .ddc_mode_o(ddc_mode)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] m_ptr = 8'h00;
  logic m_req = 1'b0, m_ddc = 1'b0;
  logic [7:0] wbuf [8];

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] p);
    case (p)
      8'h1A: return m_req ? 8'h06 : 8'h00;
      8'h1B: return 8'hB0;
      8'h3D: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] d);
    if (m_ptr == 8'h1A) begin
      if (d[2]) begin
        m_req = 1'b1;
        if (d[1]) m_ddc = 1'b1;
      end else begin
        m_req = 1'b0;
        m_ddc = 1'b0;
      end
    end
    m_ptr = m_ptr + 8'd1;
  endtask

  task automatic hw(); repeat (H) @(negedge clk); endtask

  task automatic put_bit(input logic b);
    m_low = !b; hw(); m_scl = 1'b1; hw(); m_scl = 1'b0; hw();
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; hw(); m_scl = 1'b1; hw(); b = sda_bus; m_scl = 1'b0; hw();
  endtask

  task automatic bus_start();
    m_low = 1'b0; hw(); m_scl = 1'b1; hw(); m_low = 1'b1; hw(); m_scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; hw(); m_scl = 1'b1; hw(); m_low = 1'b0; hw(); hw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!give_ack);
  endtask

  task automatic wr_txn(input logic [7:0] p, input int n, input string tag);
    logic a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); chk(8'(a), 8'd1, {tag, " R1 addr ack"});
    send_byte(p, a);            chk(8'(a), 8'd1, {tag, " R11 ptr ack"});
    m_ptr = p;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);    chk(8'(a), 8'd1, {tag, " R11 data ack"});
      model_write(wbuf[i]);
    end
    bus_stop();
    chk(8'(ddc_mode), 8'(m_ddc), {tag, " R6 ddc_mode"});
  endtask

  task automatic rd_txn(input logic set_ptr, input logic [7:0] p, input int n, input string tag);
    logic a;
    logic [7:0] d;
    bus_start();
    if (set_ptr) begin
      send_byte({ADDR, 1'b0}, a); chk(8'(a), 8'd1, {tag, " R1 addr ack"});
      send_byte(p, a);            chk(8'(a), 8'd1, {tag, " R2 ptr ack"});
      m_ptr = p;
      bus_start();
    end
    send_byte({ADDR, 1'b1}, a);   chk(8'(a), 8'd1, {tag, " R12 read addr ack"});
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d, exp_read(m_ptr), {tag, " R3 R12 read data"});
      m_ptr = m_ptr + 8'd1;
    end
    hw(); hw();
    chk(8'(sda_oe), 8'd0, {tag, " R11 released after refusal"});
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(8'(sda_oe), 8'd0, "R10 sda released");
    chk(8'(ddc_mode), 8'd0, "R10 ddc off");
    rd_txn(1'b0, 8'h00, 1, "R10 pointer zero");

    // R1: a foreign address is refused and the line stays released
    bus_start();
    send_byte({7'h22, 1'b0}, a); chk(8'(a), 8'd0, "R1 foreign addr refused");
    send_byte(8'hFF, a);         chk(8'(a), 8'd0, "R1 foreign data refused");
    bus_stop();

    rd_txn(1'b1, 8'h1B, 1, "R4 id");
    rd_txn(1'b1, 8'h3D, 2, "R5 irq");
    wbuf[0] = 8'h04; wr_txn(8'h1A, 1, "R6 request only");
    rd_txn(1'b1, 8'h1A, 1, "R8 echo");
    wbuf[0] = 8'h06; wr_txn(8'h1A, 1, "R6 grant");
    wbuf[0] = 8'h00; wr_txn(8'h1B, 1, "R9 other write");
    rd_txn(1'b1, 8'h40, 2, "R9 other read");
    wbuf[0] = 8'h02; wr_txn(8'h1A, 1, "R7 clear");
    rd_txn(1'b1, 8'h1A, 1, "R7 R8 echo cleared");
    wbuf[0] = 8'h55; wbuf[1] = 8'h06; wr_txn(8'h19, 2, "R3 write increment");
    rd_txn(1'b1, 8'hFF, 3, "R3 wrap");
    rd_txn(1'b0, 8'h00, 2, "R12 continue");

    for (int it = 0; it < 50; it++) begin
      logic [7:0] p;
      int n;
      case ($urandom % 6)
        0: p = 8'h1A; 1: p = 8'h1B; 2: p = 8'h3D; 3: p = 8'h19; 4: p = 8'hFF;
        default: p = 8'($urandom);
      endcase
      n = int'($urandom % 4);
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
      case ($urandom % 3)
        0: wr_txn(p, n, "R2 R6 random write");
        1: rd_txn(1'b1, p, n + 1, "R3 random read");
        default: rd_txn(1'b0, p, n + 1, "R12 random plain read");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule